// File: doc/BRIEF.md
# Authentication Tag Finalizer

This block closes out an authenticated-encryption pass. It takes a five-word, 128-bit-per-word cipher state, the associated-data length and the payload length in bytes, and it produces a 128-bit authentication tag. It can also compare that tag against a received tag over a selectable number of leading bytes. Once the caller pulses `start_i`, the block captures the state and folds the two bit lengths into the fourth state word. It then runs that absorb word through the state updater seven times in a row and XORs the five resulting words into the tag.

A three-state machine drives the sequence. In IDLE the block waits. When a start strobe arrives, IDLE moves to ABSORB, and the inputs are captured on that same edge. ABSORB stays in ABSORB for six edges and moves to DONE on the seventh update. DONE goes back to IDLE unconditionally after one cycle. `done_o` is high only in DONE. The tag stays on `tag_o` from then until the next accepted start.

Top module: `tagfin_engine`

## Requirements
- R1: After reset `done_o`, `match_o` and `tag_o` are all zero.
- R2: At the start edge the absorb word is captured as S3 XOR L. S3 is word 3 of `state_i`, and word j of `state_i` occupies bits [128j+127:128j]. L[63:0] is `ad_len_i` times 8 and L[127:64] is `msg_len_i` times 8, each taken modulo 2^64.
- R3: Finalization applies exactly seven updates with the same absorb word M. Each update sets S0' = S0 ^ F(S4) ^ M and Sj' = Sj ^ F(Sj-1) for j = 1..4, where F is the keyless cipher round of R4.
- R4: F maps byte k of a word (bits [8k+7:8k]) as follows. Byte k is taken as row k mod 4 of column k div 4. F applies the row rotation (output row r, column c takes input column (c+r) mod 4), then byte substitution with the standard 8-bit S-box, then the standard column mix over GF(2^8) with polynomial 0x11B.
- R5: The tag equals S0 ^ S1 ^ S2 ^ S3 ^ S4 taken after the seventh update.
- R6: `done_o` is high for exactly one cycle, the cycle that follows the eighth rising edge when the edge that samples `start_i` counts as the first.
- R7: When the tag length is between 1 and 16, `match_o` is high during done only if tag bytes 0 through tag length minus 1 equal the same bytes of `exp_tag_i`. Bytes above that range have no effect.
- R8: When the tag length is 0, the full tag still appears on `tag_o` and no comparison is made: `match_o` stays low.
- R9: A tag length from 17 to 31 compares all 16 bytes.
- R10: A start strobe in ABSORB or DONE is ignored. Timing and tag do not change, and no new run begins.
- R11: `tag_o` holds its value after done until the next accepted start.
- R12: Changes on `state_i`, `ad_len_i` or `msg_len_i` after the start edge do not affect the running finalization.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted in IDLE only |
| state_i | input | 640 | Five 128-bit state words, word j in bits [128j+127:128j] |
| ad_len_i | input | 64 | Associated-data length in bytes |
| msg_len_i | input | 64 | Payload length in bytes |
| tag_len_i | input | 5 | Number of leading tag bytes to compare, 0 means no comparison |
| exp_tag_i | input | 128 | Received tag, byte k in bits [8k+7:8k] |
| tag_o | output | 128 | Computed tag |
| match_o | output | 1 | Compared bytes all equal, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a start strobe that arrives in the single DONE cycle. If that strobe were wrongly accepted, the tag would change only one edge after done falls. To cover it, the bench raises `start_i` exactly in the done cycle and presents a different `state_i` at the same time. It then watches `tag_o` and `done_o` over the next two cycles. A second scenario pulses start in the middle of ABSORB and also changes every sampled input during the run. For the tag-length checks, a single byte is flipped just inside or just outside the compared prefix.

// File: rtl/tagfin_pkg.sv
package tagfin_pkg;
    localparam int BLK_W  = 128;
    localparam int HALF_W = BLK_W / 2;
    localparam int NWORDS = 5;
    localparam int NBYTES = BLK_W / 8;

    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [NWORDS-1:0][BLK_W-1:0] ste_t;
    typedef enum logic [1:0] {ST_IDLE, ST_ABSORB, ST_DONE} fsm_e;

    function automatic logic [7:0] xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = xtime(sh);
        end
        return acc;
    endfunction
endpackage

// File: rtl/tagfin_sbox.sv
module tagfin_sbox
    import tagfin_pkg::*;
(
    input  logic [7:0] a,
    output logic [7:0] y
);
    logic [7:0] p2, p3, p6, p12, p15, p30, p60, p120, p240, p252, inv;

    // field inverse as a^254 through an addition chain
    always_comb begin
        p2   = gf_mul(a, a);
        p3   = gf_mul(p2, a);
        p6   = gf_mul(p3, p3);
        p12  = gf_mul(p6, p6);
        p15  = gf_mul(p12, p3);
        p30  = gf_mul(p15, p15);
        p60  = gf_mul(p30, p30);
        p120 = gf_mul(p60, p60);
        p240 = gf_mul(p120, p120);
        p252 = gf_mul(p240, p12);
        inv  = gf_mul(p252, p2);
        y    = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    end
endmodule

// File: rtl/tagfin_round.sv
module tagfin_round
    import tagfin_pkg::*;
(
    input  blk_t d,
    output blk_t q
);
    blk_t sub;

    for (genvar i = 0; i < NBYTES; i++) begin : g_sub
        localparam int ROW = i % 4;
        localparam int SRC = ROW + 4 * (((i / 4) + ROW) % 4);
        tagfin_sbox u_sb (.a(d[8*SRC +: 8]), .y(sub[8*i +: 8]));
    end

    for (genvar c = 0; c < 4; c++) begin : g_mix
        logic [7:0] b0, b1, b2, b3, t;
        always_comb begin
            b0 = sub[32*c +: 8];
            b1 = sub[32*c + 8 +: 8];
            b2 = sub[32*c + 16 +: 8];
            b3 = sub[32*c + 24 +: 8];
            t  = b0 ^ b1 ^ b2 ^ b3;
        end
        assign q[32*c +: 8]      = b0 ^ t ^ xtime(b0 ^ b1);
        assign q[32*c + 8 +: 8]  = b1 ^ t ^ xtime(b1 ^ b2);
        assign q[32*c + 16 +: 8] = b2 ^ t ^ xtime(b2 ^ b3);
        assign q[32*c + 24 +: 8] = b3 ^ t ^ xtime(b3 ^ b0);
    end
endmodule

// File: rtl/tagfin_update.sv
module tagfin_update
    import tagfin_pkg::*;
(
    input  ste_t s,
    input  blk_t m,
    output ste_t n
);
    ste_t r;

    for (genvar j = 0; j < NWORDS; j++) begin : g_rnd
        tagfin_round u_rnd (.d(s[j]), .q(r[j]));
        if (j == 0) begin : g_head
            assign n[0] = s[0] ^ r[NWORDS-1] ^ m;
        end else begin : g_tail
            assign n[j] = s[j] ^ r[j-1];
        end
    end
endmodule

// File: rtl/tagfin_engine.sv
module tagfin_engine
    import tagfin_pkg::*;
#(
    parameter int N_UPD    = 7,
    parameter int TAGLEN_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [NWORDS*BLK_W-1:0]  state_i,
    input  logic [HALF_W-1:0]        ad_len_i,
    input  logic [HALF_W-1:0]        msg_len_i,
    input  logic [TAGLEN_W-1:0]      tag_len_i,
    input  logic [BLK_W-1:0]         exp_tag_i,
    output logic [BLK_W-1:0]         tag_o,
    output logic                     match_o,
    output logic                     done_o
);
    localparam int CNT_W = (N_UPD > 1) ? $clog2(N_UPD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_UPD - 1);

    fsm_e             fsm_q;
    logic [CNT_W-1:0] cnt_q;
    ste_t             st_q, st_nxt, st_in;
    blk_t             ab_q, len_word;
    logic [NBYTES-1:0] byte_ne, byte_en;
    logic [TAGLEN_W-1:0] eff_len;

    assign st_in    = state_i;
    assign len_word = {msg_len_i << 3, ad_len_i << 3};

    tagfin_update u_upd (.s(st_q), .m(ab_q), .n(st_nxt));

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q <= ST_IDLE;
            cnt_q <= '0;
            st_q  <= '0;
            ab_q  <= '0;
        end else begin
            unique case (fsm_q)
                ST_IDLE: if (start_i) begin
                    st_q  <= st_in;
                    ab_q  <= st_in[3] ^ len_word;
                    cnt_q <= '0;
                    fsm_q <= ST_ABSORB;
                end
                ST_ABSORB: begin
                    st_q  <= st_nxt;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST) fsm_q <= ST_DONE;
                end
                ST_DONE: fsm_q <= ST_IDLE;
                default: fsm_q <= ST_IDLE;
            endcase
        end
    end

    assign eff_len = (tag_len_i > TAGLEN_W'(NBYTES)) ? TAGLEN_W'(NBYTES) : tag_len_i;

    for (genvar b = 0; b < NBYTES; b++) begin : g_cmp
        assign byte_en[b] = (TAGLEN_W'(b) < eff_len);
        assign byte_ne[b] = (tag_o[8*b +: 8] != exp_tag_i[8*b +: 8]);
    end

    // output process
    always_comb begin
        tag_o = '0;
        for (int j = 0; j < NWORDS; j++) tag_o = tag_o ^ st_q[j];
        done_o  = (fsm_q == ST_DONE);
        match_o = done_o && (tag_len_i != '0) && !(|(byte_en & byte_ne));
    end

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R3
    seven_updates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(fsm_q) == ST_ABSORB && $past(cnt_q) == LAST));
    // R10
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == ST_ABSORB && cnt_q != LAST) |=> (fsm_q == ST_ABSORB));
    // R12
    absorb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q != ST_IDLE && $past(fsm_q) != ST_IDLE) |-> $stable(ab_q));
    // R11
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fsm_q) == ST_IDLE && fsm_q == ST_IDLE) |-> $stable(tag_o));
    // R8
    nolen_nomatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_len_i == '0) |-> !match_o);
endmodule

// File: tb/tagfin_engine_test.sv
`timescale 1ns/1ps
module tagfin_engine_test;
    typedef logic [4:0][127:0] st5_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [639:0] state_i = '0;
    logic [63:0]  ad_len_i = '0, msg_len_i = '0;
    logic [4:0]   tag_len_i = '0;
    logic [127:0] exp_tag_i = '0;
    logic [127:0] tag_o;
    logic         match_o, done_o;

    int n_chk = 0, n_bad = 0;
    logic [7:0] sb [256];

    always #10 clk = ~clk;

    tagfin_engine uut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .state_i(state_i),
        .ad_len_i(ad_len_i), .msg_len_i(msg_len_i), .tag_len_i(tag_len_i),
        .exp_tag_i(exp_tag_i), .tag_o(tag_o), .match_o(match_o), .done_o(done_o));

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mulb(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [127:0] rnd(input logic [127:0] w);
        logic [7:0] s [16];
        logic [127:0] o;
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                s[r + 4*c] = sb[w[8*(r + 4*((c + r) % 4)) +: 8]];
        for (int c = 0; c < 4; c++) begin
            o[32*c +: 8]      = mulb(s[4*c],2) ^ mulb(s[4*c+1],3) ^ s[4*c+2] ^ s[4*c+3];
            o[32*c+8 +: 8]    = s[4*c] ^ mulb(s[4*c+1],2) ^ mulb(s[4*c+2],3) ^ s[4*c+3];
            o[32*c+16 +: 8]   = s[4*c] ^ s[4*c+1] ^ mulb(s[4*c+2],2) ^ mulb(s[4*c+3],3);
            o[32*c+24 +: 8]   = mulb(s[4*c],3) ^ s[4*c+1] ^ s[4*c+2] ^ mulb(s[4*c+3],2);
        end
        return o;
    endfunction

    function automatic logic [127:0] model(input st5_t s, input logic [63:0] ad, input logic [63:0] ml);
        logic [127:0] m = s[3] ^ {ml * 64'd8, ad * 64'd8};
        st5_t n;
        for (int k = 0; k < 7; k++) begin
            n[0] = s[0] ^ rnd(s[4]) ^ m;
            for (int j = 1; j < 5; j++) n[j] = s[j] ^ rnd(s[j-1]);
            s = n;
        end
        return s[0] ^ s[1] ^ s[2] ^ s[3] ^ s[4];
    endfunction

    function automatic logic exp_match(input logic [127:0] t, input logic [127:0] e, input int tl);
        int lim = (tl > 16) ? 16 : tl;
        if (tl == 0) return 1'b0;
        for (int b = 0; b < lim; b++) if (t[8*b +: 8] != e[8*b +: 8]) return 1'b0;
        return 1'b1;
    endfunction

    function automatic st5_t pattern(input logic [31:0] seed);
        st5_t s;
        for (int j = 0; j < 5; j++)
            for (int q = 0; q < 4; q++)
                s[j][32*q +: 32] = seed * 32'h9e3779b1 + 32'(j * 7 + q * 131) ^ (seed << q);
        return s;
    endfunction

    // mode: 0 plain, 1 start mid-run, 2 inputs change mid-run, 3 start in done cycle
    task automatic run_fin(input string nm, input st5_t s, input logic [63:0] ad,
                           input logic [63:0] ml, input int tl, input logic [127:0] e, input int mode);
        logic [127:0] t_exp = model(s, ad, ml);
        @(negedge clk);
        state_i = s; ad_len_i = ad; msg_len_i = ml; tag_len_i = 5'(tl); exp_tag_i = e;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            if (k < 7) chk({nm, " R6 done early"}, 128'(done_o), 128'd0);
            if (mode != 0 && k == 1) begin
                state_i = pattern(32'hdead); ad_len_i = ~ad; msg_len_i = ml + 64'd5;
            end
            start_i = (mode == 1 && k == 3) || (mode == 3 && k == 7);
        end
        chk({nm, " R6 done"}, 128'(done_o), 128'd1);
        chk({nm, " R5 tag"}, tag_o, t_exp);
        chk({nm, " R7 match"}, 128'(match_o), 128'(exp_match(t_exp, e, tl)));
        @(negedge clk);
        start_i = 1'b0;
        chk({nm, " R6 done falls"}, 128'(done_o), 128'd0);
        chk({nm, " R11 tag hold"}, tag_o, t_exp);
        @(negedge clk);
        chk({nm, " R10 no restart"}, tag_o, t_exp);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 done", 128'(done_o), 128'd0);
        chk("R1 match", 128'(match_o), 128'd0);
        chk("R1 tag", tag_o, 128'd0);
    endtask

    task automatic t_compare();
        st5_t s = pattern(32'h1234);
        logic [127:0] t = model(s, 64'd13, 64'd1000);
        run_fin("R7 full", s, 64'd13, 64'd1000, 16, t, 0);
        run_fin("R7 beyond prefix", s, 64'd13, 64'd1000, 5, t ^ (128'hff << 56), 0);
        run_fin("R7 inside prefix", s, 64'd13, 64'd1000, 5, t ^ (128'h01 << 32), 0);
        run_fin("R9 long exact", s, 64'd13, 64'd1000, 20, t, 0);
        run_fin("R9 long byte15", s, 64'd13, 64'd1000, 20, t ^ (128'h80 << 120), 0);
        run_fin("R8 zero len", s, 64'd13, 64'd1000, 0, t, 0);
    endtask

    task automatic t_lengths();
        run_fin("R3 zero state", '0, 64'd0, 64'd0, 0, '0, 0);
        run_fin("R2 wrap", pattern(32'h77), 64'hffff_ffff_ffff_fff3, 64'h2000_0000_0000_0001, 1, '0, 0);
        run_fin("R4 pattern", pattern(32'hbeef), 64'd1, 64'd0, 16, '0, 0);
    endtask

    task automatic t_busy();
        run_fin("R10 mid start", pattern(32'h55), 64'd40, 64'd7, 3, '0, 1);
        run_fin("R12 input change", pattern(32'h66), 64'd9, 64'd17, 0, '0, 2);
        run_fin("R10 done start", pattern(32'h88), 64'd2, 64'd3, 16, '0, 3);
    endtask

    initial begin
        for (int x = 0; x < 256; x++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] r;
            for (int y = 1; y < 256; y++) if (x != 0 && mulb(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
            for (int i = 0; i < 8; i++)
                r[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1'b1);
            sb[x] = r;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_lengths();
        t_compare();
        t_busy();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule